// File: doc/BRIEF.md
# Unscaled-Offset Vector Load/Store Address Unit

This unit takes one 32-bit instruction word at a time. It checks whether the word encodes a vector register load or store that uses a signed, unscaled byte offset. When it does, the unit forms the memory address, the access size, the byte strobes and, for a store, the write data. It then presents a single request on a valid/ready output stream. The base comes from a general register or, when the base index is 31, from the stack pointer. The base is never written back.

The input and output are both valid/ready streams. The input is accepted only when no request is pending, or when the pending request is being taken on the same edge (`in_ready = !req_valid || req_ready`). A request stays stable until `req_ready` is sampled high. While it waits, further instructions are held off. The unit reads registers combinationally during the accept cycle. It drives the base index onto `gpr_rd_idx` and the data register index onto `vreg_rd_idx`, and it samples the returned data on the same edge.

There are three exception outcomes: undefined encoding, floating-point trap and stack alignment fault. Each one replaces the request. Each is a plain one-cycle pulse in the cycle after the instruction is accepted.

Top module: `vec_unscaled_lsu`

## Requirements
- R1: A word is recognised only when bits 29:27 = 111, bit 26 = 1, bits 25:24 = 00, bit 21 = 0 and bits 11:10 = 00. The fields are size = 31:30, opc = 23:22, imm9 = 20:12, base index = 9:5 and data register = 4:0. An unrecognised word is accepted and produces no request and no flag.
- R2: The scale is {opc[1], size[1:0]}. A scale above 4 pulses `undef_flag` and issues no request. This takes priority over every other outcome.
- R3: The byte count is 1 << scale (1, 2, 4, 8 or 16). `req_strb` has exactly the low byte-count bits set.
- R4: `req_addr` equals the base plus imm9 sign-extended to 64 bits, modulo 2^64. The offset range is -256 to 255.
- R5: A base index of 31 selects `sp_value` as the base. Any other index selects `gpr_rd_data`.
- R6: With base index 31, if `sp_value[3:0]` is not zero, `align_fault` pulses and no request is issued.
- R7: opc[0] = 1 gives a load (`req_is_load` = 1) with `req_wdata` zero. opc[0] = 0 gives a store whose write data holds the low byte-count bytes of `vreg_rd_data`, with all higher bytes zero.
- R8: `req_tag_check` is 1 exactly when the base index is not 31.
- R9: For a recognised word with a legal scale, `fp_enable` low pulses `fp_trap` and issues no request. The trap outranks the alignment check.
- R10: All results appear in the cycle after the accepting edge. Flags are one-cycle pulses, and a cycle with no accept leaves all flags low.
- R11: While `req_valid` is high and `req_ready` is low, the request fields stay unchanged and `in_ready` is low.
- R12: `gpr_rd_idx` equals bits 9:5 and `vreg_rd_idx` equals bits 4:0 of `in_insn`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word valid |
| in_ready | output | 1 | Unit can accept an instruction |
| in_insn | input | 32 | Instruction word |
| fp_enable | input | 1 | Vector/floating-point access enabled |
| sp_value | input | 64 | Current stack pointer |
| gpr_rd_idx | output | 5 | General register read index |
| gpr_rd_data | input | 64 | General register read data |
| vreg_rd_idx | output | 5 | Vector register read index |
| vreg_rd_data | input | 128 | Vector register read data |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | 64 | Byte address |
| req_bytes | output | 5 | Access size in bytes |
| req_strb | output | 16 | Byte lane enables |
| req_wdata | output | 128 | Store data in low lanes |
| req_is_load | output | 1 | 1 = load, 0 = store |
| req_tag_check | output | 1 | Access is subject to tag checking |
| undef_flag | output | 1 | Undefined encoding pulse |
| fp_trap | output | 1 | Disabled-access trap pulse |
| align_fault | output | 1 | Stack pointer misalignment pulse |

## Verification
Read indices are combinational, so they are checked in the same half-cycle as the drive. Every request field and every flag is due exactly one clock after the accepting edge. The bench drives on a falling edge, lets one rising edge accept, and samples at the next falling edge. It samples again one cycle later to confirm that the flags have dropped and the request was consumed. For back-pressure, the bench holds `req_ready` low for several cycles and samples the held request and `in_ready` at each falling edge. It then releases `req_ready` and checks the queued instruction one cycle after the release edge.

// File: rtl/vsu_pkg.sv
package vsu_pkg;

  typedef enum logic [2:0] {
    ACT_IGNORE = 3'd0,
    ACT_REQ    = 3'd1,
    ACT_UNDEF  = 3'd2,
    ACT_TRAP   = 3'd3,
    ACT_ALIGN  = 3'd4
  } vsu_action_e;

  typedef struct packed {
    logic [1:0] size;
    logic [1:0] opc;
    logic [8:0] imm9;
    logic [4:0] rn;
    logic [4:0] rt;
  } vsu_fields_t;

  localparam logic [4:0] SP_INDEX  = 5'd31;
  localparam int         MAX_SCALE = 4;

endpackage

// File: rtl/vsu_decode.sv
module vsu_decode
  import vsu_pkg::*;
#(
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic [31:0]              insn,
  input  logic                     fp_enable,
  input  logic [SP_ALIGN_BITS-1:0] sp_low,
  output vsu_fields_t              fields,
  output logic [2:0]               scale,
  output logic                     is_load,
  output logic                     uses_sp,
  output vsu_action_e              action
);

  logic recognised;
  logic scale_bad;
  logic sp_misaligned;

  always_comb begin
    fields.size = insn[31:30];
    fields.opc  = insn[23:22];
    fields.imm9 = insn[20:12];
    fields.rn   = insn[9:5];
    fields.rt   = insn[4:0];
  end

  assign recognised    = (insn[29:27] == 3'b111) && insn[26] &&
                         (insn[25:24] == 2'b00) && !insn[21] &&
                         (insn[11:10] == 2'b00);
  assign scale         = {fields.opc[1], fields.size};
  assign scale_bad     = (int'(scale) > MAX_SCALE);
  assign is_load       = fields.opc[0];
  assign uses_sp       = (fields.rn == SP_INDEX);
  assign sp_misaligned = uses_sp && (sp_low != '0);

  // priority: undefined, then trap, then alignment
  always_comb begin
    if (!recognised)        action = ACT_IGNORE;
    else if (scale_bad)     action = ACT_UNDEF;
    else if (!fp_enable)    action = ACT_TRAP;
    else if (sp_misaligned) action = ACT_ALIGN;
    else                    action = ACT_REQ;
  end

endmodule

// File: rtl/vsu_addr_gen.sv
module vsu_addr_gen #(
  parameter int XLEN    = 64,
  parameter int VLEN    = 128,
  parameter int LANES   = VLEN / 8,
  parameter int BYTES_W = $clog2(LANES) + 1
) (
  input  logic [XLEN-1:0]    base,
  input  logic [8:0]         imm9,
  input  logic [2:0]         scale,
  input  logic               is_load,
  input  logic [VLEN-1:0]    vdata,
  output logic [XLEN-1:0]    addr,
  output logic [BYTES_W-1:0] bytes,
  output logic [LANES-1:0]   strb,
  output logic [VLEN-1:0]    wdata
);

  logic [XLEN-1:0] offset;

  assign offset = {{(XLEN-9){imm9[8]}}, imm9};
  assign addr   = base + offset;
  assign bytes  = BYTES_W'(1) << scale;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign strb[g]          = (g < int'(bytes));
    assign wdata[8*g +: 8]  = (strb[g] && !is_load) ? vdata[8*g +: 8] : 8'h00;
  end

endmodule

// File: rtl/vec_unscaled_lsu.sv
module vec_unscaled_lsu
  import vsu_pkg::*;
#(
  parameter int XLEN          = 64,
  parameter int VLEN          = 128,
  parameter int SP_ALIGN_BITS = 4,
  parameter int LANES         = VLEN / 8,
  parameter int BYTES_W       = $clog2(LANES) + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [31:0]        in_insn,
  input  logic               fp_enable,
  input  logic [XLEN-1:0]    sp_value,
  output logic [4:0]         gpr_rd_idx,
  input  logic [XLEN-1:0]    gpr_rd_data,
  output logic [4:0]         vreg_rd_idx,
  input  logic [VLEN-1:0]    vreg_rd_data,
  output logic               req_valid,
  input  logic               req_ready,
  output logic [XLEN-1:0]    req_addr,
  output logic [BYTES_W-1:0] req_bytes,
  output logic [LANES-1:0]   req_strb,
  output logic [VLEN-1:0]    req_wdata,
  output logic               req_is_load,
  output logic               req_tag_check,
  output logic               undef_flag,
  output logic               fp_trap,
  output logic               align_fault
);

  vsu_fields_t        fields;
  logic [2:0]         scale;
  logic               is_load;
  logic               uses_sp;
  vsu_action_e        action;
  logic [XLEN-1:0]    base;
  logic [XLEN-1:0]    nxt_addr;
  logic [BYTES_W-1:0] nxt_bytes;
  logic [LANES-1:0]   nxt_strb;
  logic [VLEN-1:0]    nxt_wdata;
  logic               accept;

  vsu_decode #(.SP_ALIGN_BITS(SP_ALIGN_BITS)) u_decode (
    .insn      (in_insn),
    .fp_enable (fp_enable),
    .sp_low    (sp_value[SP_ALIGN_BITS-1:0]),
    .fields    (fields),
    .scale     (scale),
    .is_load   (is_load),
    .uses_sp   (uses_sp),
    .action    (action)
  );

  assign gpr_rd_idx  = fields.rn;
  assign vreg_rd_idx = fields.rt;
  assign base        = uses_sp ? sp_value : gpr_rd_data;

  vsu_addr_gen #(.XLEN(XLEN), .VLEN(VLEN), .LANES(LANES), .BYTES_W(BYTES_W)) u_addr (
    .base    (base),
    .imm9    (fields.imm9),
    .scale   (scale),
    .is_load (is_load),
    .vdata   (vreg_rd_data),
    .addr    (nxt_addr),
    .bytes   (nxt_bytes),
    .strb    (nxt_strb),
    .wdata   (nxt_wdata)
  );

  assign in_ready = !req_valid || req_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_valid     <= 1'b0;
      req_addr      <= '0;
      req_bytes     <= '0;
      req_strb      <= '0;
      req_wdata     <= '0;
      req_is_load   <= 1'b0;
      req_tag_check <= 1'b0;
      undef_flag    <= 1'b0;
      fp_trap       <= 1'b0;
      align_fault   <= 1'b0;
    end else begin
      undef_flag  <= accept && (action == ACT_UNDEF);
      fp_trap     <= accept && (action == ACT_TRAP);
      align_fault <= accept && (action == ACT_ALIGN);
      if (accept) begin
        req_valid <= (action == ACT_REQ);
        if (action == ACT_REQ) begin
          req_addr      <= nxt_addr;
          req_bytes     <= nxt_bytes;
          req_strb      <= nxt_strb;
          req_wdata     <= nxt_wdata;
          req_is_load   <= is_load;
          req_tag_check <= !uses_sp;
        end
      end else if (req_ready) begin
        req_valid <= 1'b0;
      end
    end
  end

  // R11: a stalled request is frozen and blocks the input
  assert_hold_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) &&
      $stable(req_strb) && $stable(req_wdata) && $stable(req_is_load)));

  assert_stall_blocks_input_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> !in_ready);

  // R3: strobe population equals byte count
  assert_strb_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> ($countones(req_strb) == int'(req_bytes)));

  // R2/R9/R6: at most one exception, never alongside a request
  assert_flags_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({undef_flag, fp_trap, align_fault}));

  assert_flag_no_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (undef_flag || fp_trap || align_fault) |-> !req_valid);

  // R10: no accept on an edge means no flag after it
  assert_flags_need_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !(undef_flag || fp_trap || align_fault));

  // R7: loads carry no write data
  assert_load_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_is_load) |-> (req_wdata == '0));

endmodule

// File: tb/vec_unscaled_lsu_bench.sv
`timescale 1ns/1ps
module vec_unscaled_lsu_bench;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [31:0]  in_insn;
  logic         fp_enable;
  logic [63:0]  sp_value;
  logic [4:0]   gpr_rd_idx;
  logic [63:0]  gpr_rd_data;
  logic [4:0]   vreg_rd_idx;
  logic [127:0] vreg_rd_data;
  logic         req_valid;
  logic         req_ready;
  logic [63:0]  req_addr;
  logic [4:0]   req_bytes;
  logic [15:0]  req_strb;
  logic [127:0] req_wdata;
  logic         req_is_load;
  logic         req_tag_check;
  logic         undef_flag;
  logic         fp_trap;
  logic         align_fault;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  function automatic logic [63:0] gpr_val(input logic [4:0] i);
    return 64'hF000_1234_0000_0000 + {59'd0, i} * 64'h0001_0203_0405_0607;
  endfunction

  function automatic logic [127:0] vreg_val(input logic [4:0] i);
    return {32'h0123_4567 ^ {27'd0, i}, 32'h89AB_CDEF + {27'd0, i},
            32'h5A5A_0000 | {27'd0, i}, 32'hC3D2_E1F0 - {27'd0, i}};
  endfunction

  assign gpr_rd_data  = gpr_val(gpr_rd_idx);
  assign vreg_rd_data = vreg_val(vreg_rd_idx);

  vec_unscaled_lsu u_vec_unscaled_lsu (
    .clk, .rst_n, .in_valid, .in_ready, .in_insn, .fp_enable, .sp_value,
    .gpr_rd_idx, .gpr_rd_data, .vreg_rd_idx, .vreg_rd_data,
    .req_valid, .req_ready, .req_addr, .req_bytes, .req_strb, .req_wdata,
    .req_is_load, .req_tag_check, .undef_flag, .fp_trap, .align_fault
  );

  function automatic logic [31:0] mk(input logic [1:0] size, input logic [1:0] opc,
                                     input logic [8:0] imm, input logic [4:0] rn,
                                     input logic [4:0] rt);
    return {size, 3'b111, 1'b1, 2'b00, opc, 1'b0, imm, 2'b00, rn, rt};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act,
                     input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // expected outcome computed from the requirements
  typedef struct {
    bit           rq, ud, tr, al;
    logic [63:0]  addr;
    logic [4:0]   bytes;
    logic [15:0]  strb;
    logic [127:0] wdata;
    bit           ld, tag;
  } exp_t;

  function automatic exp_t model(input logic [31:0] w, input bit fp, input logic [63:0] sp);
    exp_t e;
    bit rec;
    int sc;
    logic [63:0] b;
    e = '{default: 0};
    rec = (w[29:27] == 3'b111) && w[26] && (w[25:24] == 2'b00) && !w[21] && (w[11:10] == 2'b00);
    sc  = {w[23], w[31:30]};
    if (!rec) return e;
    if (sc > 4) begin e.ud = 1; return e; end
    if (!fp) begin e.tr = 1; return e; end
    if (w[9:5] == 5'd31 && sp[3:0] != 0) begin e.al = 1; return e; end
    e.rq    = 1;
    b       = (w[9:5] == 5'd31) ? sp : gpr_val(w[9:5]);
    e.addr  = b + {{55{w[20]}}, w[20:12]};
    e.bytes = 5'(1 << sc);
    e.strb  = 16'((17'h1 << e.bytes) - 1);
    e.ld    = w[22];
    e.tag   = (w[9:5] != 5'd31);
    for (int k = 0; k < 16; k++)
      e.wdata[8*k +: 8] = (!e.ld && e.strb[k]) ? vreg_val(w[4:0])[8*k +: 8] : 8'h00;
    return e;
  endfunction

  task automatic check_out(input exp_t e, input string tag);
    chk(req_valid == e.rq, {tag, " R1/R10 req_valid"}, req_valid, e.rq);
    chk(undef_flag == e.ud, {tag, " R2 undef_flag"}, undef_flag, e.ud);
    chk(fp_trap == e.tr, {tag, " R9 fp_trap"}, fp_trap, e.tr);
    chk(align_fault == e.al, {tag, " R6 align_fault"}, align_fault, e.al);
    if (e.rq) begin
      chk(req_addr == e.addr, {tag, " R4/R5 req_addr"}, req_addr, e.addr);
      chk(req_bytes == e.bytes, {tag, " R3 req_bytes"}, req_bytes, e.bytes);
      chk(req_strb == e.strb, {tag, " R3 req_strb"}, req_strb, e.strb);
      chk(req_wdata == e.wdata, {tag, " R7 req_wdata"}, req_wdata, e.wdata);
      chk(req_is_load == e.ld, {tag, " R7 req_is_load"}, req_is_load, e.ld);
      chk(req_tag_check == e.tag, {tag, " R8 req_tag_check"}, req_tag_check, e.tag);
    end
  endtask

  // one instruction: drive at negedge, accept at posedge, check one cycle later
  task automatic run_one(input logic [31:0] w, input bit fp, input logic [63:0] sp,
                         input string tag);
    exp_t e;
    e = model(w, fp, sp);
    @(negedge clk);
    in_valid = 1; in_insn = w; fp_enable = fp; sp_value = sp; req_ready = 1;
    #1;
    chk(gpr_rd_idx == w[9:5], {tag, " R12 gpr_rd_idx"}, gpr_rd_idx, w[9:5]);
    chk(vreg_rd_idx == w[4:0], {tag, " R12 vreg_rd_idx"}, vreg_rd_idx, w[4:0]);
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check_out(e, tag);
    @(negedge clk);
    chk(!(undef_flag || fp_trap || align_fault || req_valid), {tag, " R10 pulse drop"},
        {undef_flag, fp_trap, align_fault, req_valid}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    exp_t e1, e2;
    logic [31:0] w1, w2;
    void'($urandom(32'd2024));
    rst_n = 0; in_valid = 0; in_insn = 0; fp_enable = 1; sp_value = 0; req_ready = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    chk(!req_valid && !undef_flag && !fp_trap && !align_fault && in_ready, "R10 reset state",
        {req_valid, undef_flag, fp_trap, align_fault, in_ready}, 1);

    // directed corners
    run_one(mk(2'b00, 2'b00, 9'h0FF, 5'd3, 5'd7), 1, 64'h1000, "byte store +255");
    run_one(mk(2'b01, 2'b01, 9'h100, 5'd9, 5'd2), 1, 64'h1000, "half load -256");
    run_one(mk(2'b10, 2'b00, 9'h1FF, 5'd31, 5'd4), 1, 64'h8000, "word store sp -1");
    run_one(mk(2'b11, 2'b00, 9'h010, 5'd0, 5'd31), 1, 64'h8000, "dword store");
    run_one(mk(2'b00, 2'b10, 9'h008, 5'd31, 5'd12), 1, 64'h0, "quad store sp wrap");
    run_one(mk(2'b00, 2'b11, 9'h004, 5'd5, 5'd12), 1, 64'h0, "quad load");
    run_one(mk(2'b01, 2'b10, 9'h000, 5'd5, 5'd1), 1, 64'h0, "R2 scale5 undef");
    run_one(mk(2'b11, 2'b11, 9'h000, 5'd5, 5'd1), 0, 64'h0, "R2 scale7 over trap");
    run_one(mk(2'b10, 2'b00, 9'h000, 5'd31, 5'd1), 0, 64'h8, "R9 trap over align");
    run_one(mk(2'b10, 2'b00, 9'h000, 5'd31, 5'd1), 1, 64'h8, "R6 sp misaligned");
    run_one(mk(2'b10, 2'b00, 9'h000, 5'd30, 5'd1), 1, 64'h8, "R6 rn30 no check");
    run_one(mk(2'b10, 2'b00, 9'h000, 5'd3, 5'd1) | 32'h0000_0400, 1, 64'h0, "R1 bit10 set");
    run_one(mk(2'b10, 2'b00, 9'h000, 5'd3, 5'd1) | 32'h0020_0000, 1, 64'h0, "R1 bit21 set");

    // R11 back-pressure
    w1 = mk(2'b11, 2'b00, 9'h020, 5'd6, 5'd9);
    w2 = mk(2'b00, 2'b01, 9'h1F0, 5'd31, 5'd3);
    e1 = model(w1, 1, 64'h4000);
    e2 = model(w2, 1, 64'h4000);
    @(negedge clk);
    req_ready = 0; in_valid = 1; in_insn = w1; fp_enable = 1; sp_value = 64'h4000;
    @(posedge clk);
    @(negedge clk);
    in_insn = w2;
    check_out(e1, "R11 first");
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(!in_ready, "R11 in_ready low", in_ready, 0);
      check_out(e1, "R11 held");
    end
    req_ready = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    check_out(e2, "R11 queued");
    @(negedge clk);
    chk(!req_valid, "R11 drained", req_valid, 0);

    // constrained random
    for (int n = 0; n < 400; n++) begin
      logic [31:0] w;
      logic [63:0] sp;
      bit fp;
      logic [4:0] rn;
      rn = ($urandom % 4 == 0) ? 5'd31 : 5'($urandom);
      w  = mk(2'($urandom), 2'($urandom), 9'($urandom), rn, 5'($urandom));
      if ($urandom % 10 == 0) w = $urandom & 32'hFBFF_FFFF;
      fp = ($urandom % 10 != 0);
      sp = {$urandom, $urandom};
      if ($urandom % 10 < 7) sp[3:0] = 4'h0;
      run_one(w, fp, sp, "random");
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule